// File: doc/BRIEF.md
# Selectable 5x5 Streaming Image Filter

The block filters a raster stream of 8-bit grayscale pixels with a 5x5 kernel, one pixel per valid sample. It keeps the four previous image lines in its own storage and builds the 5x5 neighbourhood from them. Each of the five window rows passes through its own five-tap multiply-accumulate row filter, and the five row results are added to give one output pixel.

The kernel comes from a bank of nine preset coefficient sets held on chip. Each set has its own right-shift for scaling, and the scaled sum is clamped to the pixel range. A frame starts with a pixel flagged as start-of-frame. The kernel choice and the line length are captured with that pixel and hold for the whole frame, so a host can change them at any time without tearing an image.

Top module: `stream_filter5x5`

## Requirements
- R1: After reset, and before any pixel has been sampled, out_valid is 0 and out_pix is 0.
- R2: A sampled pixel with in_sof=1 is row 0, column 0 of a new frame. Every sampled pixel moves the column on by one. After line_len pixels the column returns to 0 and the row increments. Cycles with in_valid=0 move nothing, and a new in_sof restarts the position even in the middle of a line.
- R3: For the pixel at row R, column C, the output is the sum of k[r][c] * img[R-4+r][C-4+c] over r,c in 0..4. Kernel row 0 pairs with the line four lines earlier, and kernel column 0 pairs with the pixel four samples earlier in the same line.
- R4: out_valid is 1 exactly two clock cycles after a pixel with row >= 4 and column >= 4 is sampled. In every other cycle out_valid is 0 and out_pix is 0. A start-of-frame pixel never produces a valid output.
- R5: The nine kernels are coded 0..8. With dr=r-2, dc=c-2, b=(1,4,6,4,1) and g=(-1,-2,0,2,1), they are (coefficients, shift):
  - 0: 1 at the centre only, shift 0.
  - 1: all 25 ones, shift 5.
  - 2: ones where |dr|,|dc| <= 1, shift 3.
  - 3: b[r]*b[c], shift 8.
  - 4: b[r]*g[c], shift 5.
  - 5: g[r]*b[c], shift 5.
  - 6: centre 24 and others -1, shift 0.
  - 7: centre 40 and others -1, shift 4.
  - 8: ones where r==c, shift 2.
- R6: A kern_sel code of 9 to 15 selects kernel 0.
- R7: kern_sel and line_len are sampled only with a valid start-of-frame pixel. Changes at any other time have no effect on the outputs of the current frame.
- R8: The sum is shifted right arithmetically (rounding toward minus infinity) by the kernel's shift. Results below 0 become 0 and results above 255 become 255.
- R9: Line lengths from 5 to 512 pixels are filtered correctly, including the 512 case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_sof | input | 1 | Marks the first pixel of a frame (with in_valid) |
| in_pix | input | 8 | Grayscale input pixel |
| line_len | input | 10 | Pixels per line, 5..512, sampled at frame start |
| kern_sel | input | 4 | Kernel code, sampled at frame start |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | 8 | Filtered, scaled and clamped pixel |

## Verification
The assertions check several rules on every cycle:
- a low out_valid always comes with a zero pixel;
- a valid output always has a sampled input two cycles earlier;
- a start-of-frame pixel never yields a valid output;
- the active kernel changes only at a frame start and always holds a legal code;
- the column stays below the latched line length.

The arithmetic cannot be shown by those checks. This covers the tap ordering, the coefficients of each kernel, the floor shift and the clamping, the handling of gaps and aborted frames, and the 512-pixel lines. The bench's behavioural convolution shows these by comparing every output cycle for all nine kernels and the remapped codes.

// File: rtl/sf5_pkg.sv
package sf5_pkg;
  localparam int TAPS     = 5;
  localparam int NUM_KERN = 9;
  localparam int PIX_W    = 8;
  localparam int COEF_W   = 8;
  localparam int SHIFT_W  = 4;
  localparam int KSEL_W   = $clog2(NUM_KERN);
  localparam int ACC_W    = PIX_W + 1 + COEF_W + $clog2(TAPS * TAPS);

  typedef logic [PIX_W-1:0]         pix_t;
  typedef logic signed [COEF_W-1:0] coef_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  function automatic int binom_w(input int i);
    case (i)
      0, 4:    return 1;
      1, 3:    return 4;
      default: return 6;
    endcase
  endfunction

  function automatic int slope_w(input int i);
    case (i)
      0:       return -1;
      1:       return -2;
      3:       return 2;
      4:       return 1;
      default: return 0;
    endcase
  endfunction

  // Preset coefficient of kernel k at window row r, column c.
  function automatic coef_t preset_coef(input int k, input int r, input int c);
    int v;
    logic ctr;
    ctr = (r == 2) && (c == 2);
    case (k)
      0:       v = ctr ? 1 : 0;
      1:       v = 1;
      2:       v = (r >= 1 && r <= 3 && c >= 1 && c <= 3) ? 1 : 0;
      3:       v = binom_w(r) * binom_w(c);
      4:       v = binom_w(r) * slope_w(c);
      5:       v = slope_w(r) * binom_w(c);
      6:       v = ctr ? 24 : -1;
      7:       v = ctr ? 40 : -1;
      8:       v = (r == c) ? 1 : 0;
      default: v = 0;
    endcase
    return coef_t'(v);
  endfunction

  function automatic logic [SHIFT_W-1:0] preset_shift(input int k);
    case (k)
      1, 4, 5: return SHIFT_W'(5);
      2:       return SHIFT_W'(3);
      3:       return SHIFT_W'(8);
      7:       return SHIFT_W'(4);
      8:       return SHIFT_W'(2);
      default: return SHIFT_W'(0);
    endcase
  endfunction

  // Floor shift then clamp to the pixel range.
  function automatic pix_t scale_sat(input acc_t acc, input logic [SHIFT_W-1:0] sh);
    acc_t s;
    s = acc >>> sh;
    if (s < 0)        return '0;
    else if (s > 255) return '1;
    else              return s[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/sf5_line_delay.sv
module sf5_line_delay
  import sf5_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  pix_t              din,
  output pix_t              dout
);
  pix_t mem [DEPTH];

  // Read-before-write at the same column: one whole line of delay.
  assign dout = mem[addr];

  always_ff @(posedge clk) begin
    if (en) mem[addr] <= din;
  end
endmodule

// File: rtl/sf5_row_mac.sv
module sf5_row_mac
  import sf5_pkg::*;
(
  input  pix_t  px  [TAPS],
  input  coef_t cf  [TAPS],
  output acc_t  sum
);
  always_comb begin
    acc_t pe, ce;
    sum = '0;
    for (int i = 0; i < TAPS; i++) begin
      pe  = ACC_W'($signed({1'b0, px[i]}));
      ce  = ACC_W'(cf[i]);
      sum = sum + pe * ce;
    end
  end
endmodule

// File: rtl/sf5_kernel_bank.sv
module sf5_kernel_bank
  import sf5_pkg::*;
(
  input  logic [KSEL_W-1:0]  sel,
  output coef_t              coef [TAPS][TAPS],
  output logic [SHIFT_W-1:0] shift
);
  coef_t              tab    [NUM_KERN][TAPS][TAPS];
  logic [SHIFT_W-1:0] sh_tab [NUM_KERN];

  always_comb begin
    for (int k = 0; k < NUM_KERN; k++) begin
      sh_tab[k] = preset_shift(k);
      for (int r = 0; r < TAPS; r++)
        for (int c = 0; c < TAPS; c++)
          tab[k][r][c] = preset_coef(k, r, c);
    end
  end

  always_comb begin
    coef  = tab[0];
    shift = sh_tab[0];
    for (int k = 1; k < NUM_KERN; k++) begin
      if (sel == KSEL_W'(k)) begin
        coef  = tab[k];
        shift = sh_tab[k];
      end
    end
  end
endmodule

// File: rtl/stream_filter5x5.sv
module stream_filter5x5
  import sf5_pkg::*;
#(
  parameter int MAX_LEN = 512,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [PIX_W-1:0]  in_pix,
  input  logic [LEN_W-1:0]  line_len,
  input  logic [KSEL_W-1:0] kern_sel,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_pix
);
  localparam int ADDR_W  = $clog2(MAX_LEN);
  localparam int ROW_W   = 3;
  localparam int FULL_AT = TAPS - 1;

  // Named events for the checker
  logic frame_start, line_end, win_ok;

  logic [ADDR_W-1:0] col_q, pos_col;
  logic [ROW_W-1:0]  row_q, pos_row;
  logic [LEN_W-1:0]  len_q, len_eff;
  logic [KSEL_W-1:0] kern_q;

  assign frame_start = in_valid & in_sof;
  assign pos_col     = in_sof ? '0 : col_q;
  assign pos_row     = in_sof ? '0 : row_q;
  assign len_eff     = in_sof ? line_len : len_q;
  assign line_end    = in_valid && (LEN_W'(pos_col) == len_eff - LEN_W'(1));

  // Raster position and per-frame settings
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q  <= '0;
      row_q  <= '0;
      len_q  <= LEN_W'(MAX_LEN);
      kern_q <= '0;
    end else if (in_valid) begin
      if (line_end) begin
        col_q <= '0;
        row_q <= (pos_row == ROW_W'(FULL_AT)) ? pos_row : pos_row + ROW_W'(1);
      end else begin
        col_q <= pos_col + ADDR_W'(1);
        row_q <= pos_row;
      end
      if (in_sof) begin
        len_q  <= line_len;
        kern_q <= (kern_sel < KSEL_W'(NUM_KERN)) ? kern_sel : '0;
      end
    end
  end

  // Line taps: tap[TAPS-1] is the live pixel, tap[0] the oldest line
  pix_t tap [TAPS];
  assign tap[TAPS-1] = in_pix;

  for (genvar i = 0; i < TAPS - 1; i++) begin : g_line
    sf5_line_delay #(.DEPTH(MAX_LEN), .ADDR_W(ADDR_W)) u_dly (
      .clk  (clk),
      .en   (in_valid),
      .addr (pos_col),
      .din  (tap[TAPS-1-i]),
      .dout (tap[TAPS-2-i])
    );
  end

  // 5x5 window: column TAPS-1 is the newest sample
  pix_t win [TAPS][TAPS];

  always_ff @(posedge clk) begin
    if (in_valid) begin
      for (int r = 0; r < TAPS; r++) begin
        for (int c = 0; c < TAPS - 1; c++) win[r][c] <= win[r][c+1];
        win[r][TAPS-1] <= tap[r];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) win_ok <= 1'b0;
    else        win_ok <= in_valid && (pos_row == ROW_W'(FULL_AT))
                                   && (pos_col >= ADDR_W'(FULL_AT));
  end

  // Coefficients and row filters
  coef_t              coef [TAPS][TAPS];
  logic [SHIFT_W-1:0] shift;
  acc_t               row_sum [TAPS];
  acc_t               total;

  sf5_kernel_bank u_bank (
    .sel   (kern_q),
    .coef  (coef),
    .shift (shift)
  );

  for (genvar r = 0; r < TAPS; r++) begin : g_row
    sf5_row_mac u_mac (
      .px  (win[r]),
      .cf  (coef[r]),
      .sum (row_sum[r])
    );
  end

  always_comb begin
    total = '0;
    for (int r = 0; r < TAPS; r++) total = total + row_sum[r];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= win_ok;
      out_pix   <= win_ok ? scale_sat(total, shift) : '0;
    end
  end
endmodule

// File: rtl/sf5_checker.sv
module sf5_checker
  import sf5_pkg::*;
#(
  parameter int MAX_LEN = 512,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int ADDR_W = $clog2(MAX_LEN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              frame_start,
  input logic              out_valid,
  input logic [PIX_W-1:0]  out_pix,
  input logic [KSEL_W-1:0] kern_q,
  input logic [ADDR_W-1:0] col_q,
  input logic [LEN_W-1:0]  len_q
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_pix == '0); // R4

  AST_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2)); // R4

  AST_HEAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> ##1 !out_valid); // R4

  AST_KERN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(kern_q)); // R7

  AST_KERN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    kern_q < KSEL_W'(NUM_KERN)); // R6

  AST_COL_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    len_q != '0 |-> LEN_W'(col_q) < len_q); // R2
endmodule

bind stream_filter5x5 sf5_checker #(.MAX_LEN(MAX_LEN)) u_sf5_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .frame_start (frame_start),
  .out_valid   (out_valid),
  .out_pix     (out_pix),
  .kern_q      (kern_q),
  .col_q       (col_q),
  .len_q       (len_q)
);

// File: tb/test_stream_filter5x5.sv
`timescale 1ns/1ps
module test_stream_filter5x5;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_sof = 1'b0;
  logic [7:0] in_pix = '0;
  logic [9:0] line_len = 10'd8;
  logic [3:0] kern_sel = '0;
  logic       out_valid;
  logic [7:0] out_pix;

  always #2.5 clk = ~clk;

  stream_filter5x5 i_stream_filter5x5 (
    .clk, .rst_n, .in_valid, .in_sof, .in_pix, .line_len, .kern_sel,
    .out_valid, .out_pix
  );

  int vectors = 0;
  int miscompares = 0;

  // Behavioural model state
  int    m_row = 0, m_col = 0, m_len = 8, m_kern = 0;
  int    img [8][512];
  int    ev [2] = '{0, 0};
  int    ep [2] = '{0, 0};
  string et [2] = '{"R1", "R1"};
  string tag = "R1";

  function automatic int bw(input int i);
    int d = (i > 2) ? i - 2 : 2 - i;
    return (d == 2) ? 1 : 6 - 2 * d;
  endfunction

  function automatic int gw(input int i);
    int d = i - 2;
    if (d == 0) return 0;
    return (d > 0) ? (3 - d) : -(3 + d);
  endfunction

  function automatic int kc(input int k, input int r, input int c);
    int dr = r - 2, dc = c - 2;
    bit mid = (dr == 0) && (dc == 0);
    case (k)
      0: return mid ? 1 : 0;
      1: return 1;
      2: return (dr * dr <= 1 && dc * dc <= 1) ? 1 : 0;
      3: return bw(r) * bw(c);
      4: return bw(r) * gw(c);
      5: return gw(r) * bw(c);
      6: return mid ? 24 : -1;
      7: return mid ? 40 : -1;
      default: return (dr == dc) ? 1 : 0;
    endcase
  endfunction

  function automatic int ksh(input int k);
    int t [9] = '{0, 5, 3, 8, 5, 5, 0, 4, 2};
    return t[k];
  endfunction

  function automatic int pat(input int kind, input int r, input int c);
    case (kind)
      0: return ((r * 73 + c * 151) ^ (r * c * 29 + 7)) & 255;
      1: return (r * 21 + c * 13) & 255;
      2: return 255;
      3: return ((r + c) % 2) ? 255 : 0;
      default: return 255 - ((c * 40) & 255);
    endcase
  endfunction

  // One clock: check the output, then drive the next input.
  task automatic step(input bit v, input bit s, input int p, input int len, input int ks);
    @(negedge clk);
    vectors++;
    if (out_valid !== ev[1][0] || out_pix !== ep[1][7:0]) begin
      miscompares++;
      $display("FAIL %s: out_valid=%0d out_pix=%0d expected valid=%0d pix=%0d",
               et[1], out_valid, out_pix, ev[1], ep[1]);
    end
    ev[1] = ev[0]; ep[1] = ep[0]; et[1] = et[0];
    ev[0] = 0; ep[0] = 0; et[0] = "R4";
    if (v) begin
      if (s) begin
        m_row = 0; m_col = 0; m_len = len;
        m_kern = (ks < 9) ? ks : 0;
      end
      img[m_row % 8][m_col] = p;
      if (m_row >= 4 && m_col >= 4) begin
        int acc = 0;
        for (int r = 0; r < 5; r++)
          for (int c = 0; c < 5; c++)
            acc += kc(m_kern, r, c) * img[(m_row - 4 + r) % 8][m_col - 4 + c];
        acc = acc >>> ksh(m_kern);
        ev[0] = 1;
        ep[0] = (acc < 0) ? 0 : ((acc > 255) ? 255 : acc);
        et[0] = tag;
      end
      if (m_col + 1 == m_len) begin m_col = 0; m_row++; end
      else m_col++;
    end
    in_valid = v; in_sof = s; in_pix = 8'(p);
    line_len = 10'(len); kern_sel = 4'(ks);
  endtask

  // Drive npix pixels of one frame; after the first pixel the settings
  // pins carry other values, which must be ignored (R7).
  task automatic frame(input int len, input int npix, input int ks, input int ks_mid,
                       input int kind, input int gap);
    for (int i = 0; i < npix; i++) begin
      if (gap != 0 && i % gap == gap - 1) step(0, 0, 77, len + 3, ks_mid);
      if (i == 0) step(1, 1, pat(kind, 0, 0), len, ks);
      else        step(1, 0, pat(kind, i / len, i % len), len + 3, ks_mid);
    end
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) step(0, 0, 0, 8, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, checked on the first two cycles
    tag = "R1";
    step(0, 0, 0, 8, 0);
    step(0, 0, 0, 8, 0);

    // R5: all nine kernels, several lengths and patterns, some gaps
    tag = "R5";
    for (int k = 0; k < 9; k++) begin
      frame(9 + k, 7 * (9 + k), k, k, k % 2 == 0 ? 0 : 1, (k % 3 == 0) ? 5 : 0);
      flush();
    end

    // R3: row and column tap order via asymmetric kernels on ramps
    tag = "R3";
    frame(8, 48, 4, 4, 1, 0);
    frame(8, 48, 5, 5, 1, 0);
    frame(11, 66, 8, 8, 0, 0);
    flush();

    // R6: out-of-range codes fall back to kernel 0
    tag = "R6";
    frame(7, 42, 12, 12, 0, 0);
    frame(7, 42, 15, 15, 1, 0);
    flush();

    // R7: kern_sel and line_len change mid-frame without effect
    tag = "R7";
    frame(9, 63, 3, 6, 0, 0);
    frame(6, 42, 6, 1, 1, 4);
    flush();

    // R8: clamping at both ends and floor shift of negatives
    tag = "R8";
    frame(8, 48, 7, 7, 2, 0);
    frame(8, 48, 6, 6, 3, 0);
    frame(8, 48, 4, 4, 4, 0);
    frame(8, 48, 5, 5, 3, 0);
    flush();

    // R2: idle gaps and a frame aborted in the middle of a line
    tag = "R2";
    frame(10, 70, 2, 2, 0, 3);
    frame(10, 43, 1, 1, 1, 0);
    frame(5, 30, 0, 0, 0, 2);
    frame(5, 30, 3, 3, 1, 0);
    flush();

    // R9: maximum line length
    tag = "R9";
    frame(512, 512 * 6, 1, 1, 0, 0);
    frame(512, 512 * 5 + 20, 4, 4, 1, 0);
    flush();

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule